// File: doc/BRIEF.md
# Asynchronous SRAM Bank Controller

This block sits between a synchronous host and an asynchronous static RAM module made of four byte-wide banks. The four banks share one address bus and one output-enable line. Each bank has its own active-low chip select and write enable. The host presents one request at a time on a level request / pulse acknowledge port. Each request carries an address, write data, a byte mask and a read/write flag. A mode input sets how the four banks are organised: as one 32-bit word memory, as two 16-bit memories, or as four independent 8-bit memories.

Every access goes through three phases: address setup, strobe, and (for writes) hold. Each phase lasts a whole number of controller clock cycles. That number is derived from a picosecond minimum and the clock period, and is always rounded up. A write takes place while chip select and write enable are both low. Write enable rises first, and chip select stays low through the hold phase, so data setup and hold are measured against the write enable edge. The bidirectional data pins are modelled as separate output, input and drive-enable signals. Read data is sampled in the last cycle that output enable is low and is returned with a one-cycle acknowledge.

Top module: `sram_bank_ctrl`

## Requirements
- R1: During and right after reset, all chip selects and write enables are high, output enable is high, the data drive enable is low and the acknowledge is low.
- R2: Mode code 00 selects word organisation. All four chip selects go low together, mem_addr equals req_addr[20:2], byte lane i carries req_wdata[8i+7:8i], and a read returns all 32 bits.
- R3: On a write, the write enable of lane i pulses low only if the matching mask bit is set. A write whose active mask bits are all zero lowers no write enable and leaves the memory unchanged, and it is still acknowledged.
- R4: Mode code 01 selects two halfword banks. mem_addr equals req_addr[19:1]. req_addr[20]=0 selects lanes 0/1 and req_addr[20]=1 selects lanes 2/3. req_wdata[15:0] and req_be[1:0] map to the lower and upper lane of the pair. A read returns the halfword in rsp_rdata[15:0] with zeros above.
- R5: Mode codes 10 and 11 select four byte banks. mem_addr equals req_addr[18:0], req_addr[20:19] is the bank number, req_wdata[7:0] and req_be[0] apply, and a read returns the byte in rsp_rdata[7:0] with zeros above. Chip selects and write enables of unselected banks stay high.
- R6: Write timing. Chip select falls together with the new address. Write enable stays high for SETUP cycles, is low for WPULSE cycles, and chip select stays low for HOLD cycles after write enable rises. Each count is ceil(minimum_ps / CLK_PS), at least 1. The defaults give 1, 2 and 1.
- R7: Read timing. Output enable stays high during writes. On a read it falls SETUP cycles after chip select and stays low for RSTROBE cycles (2 by default), and rsp_rdata shows the input data sampled in the last of those cycles.
- R8: The data drive enable is high only during write accesses and never while output enable is low. It rises with the chip select fall and falls HOLD cycles after write enable rises, at the same time as chip select.
- R9: The acknowledge is a one-cycle pulse in the first cycle with all chip selects high after an access. No access starts in that cycle, even if a request is still pending, so at least one full idle cycle separates accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request pending, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Host address, interpreted per mode |
| req_wdata | input | 32 | Write data, low-justified in 16/8-bit modes |
| req_be | input | 4 | Byte write mask |
| cfg_mode | input | 2 | 00 word, 01 halfword banks, 10/11 byte banks |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with req_ack on reads |
| mem_addr | output | 19 | Shared memory address |
| mem_cs_n | output | 4 | Per-bank chip select, active low |
| mem_we_n | output | 4 | Per-bank write enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dout | output | 32 | Data toward the memory pins |
| mem_din | input | 32 | Data from the memory pins |
| mem_dq_oe | output | 1 | Drive enable for mem_dout |

## Verification
Full-word writes and reads at scattered addresses show that the word address takes its bits from the right place. Partial and empty byte masks show whether each write enable follows its own mask bit. Halfword writes to both pairs at the same halfword address are read back with a single word read, which would expose a lane swap or a wrong pair select. Byte writes to all four banks at one byte address, plus a read in mode 11, show that the bank number decode is correct and that unselected banks stay quiet. Each access's pin waveform is cut into its setup, strobe and hold lengths and compared against the rounded-up cycle counts.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int unsigned LANES  = 4;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = LANES * BYTE_W;

    typedef enum logic [1:0] {
        MODE_W32  = 2'b00,
        MODE_W16  = 2'b01,
        MODE_W8   = 2'b10,
        MODE_W8_B = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    // Whole clock cycles that cover a minimum duration, never fewer than one.
    function automatic int unsigned ps_to_cycles(input int unsigned min_ps,
                                                 input int unsigned clk_ps);
        int unsigned n;
        n = (min_ps + clk_ps - 1) / clk_ps;
        return (n == 0) ? 1 : n;
    endfunction

endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 19
) (
    input  logic [1:0]          mode,
    input  logic [ADDR_W+1:0]   haddr,
    input  logic [LANES-1:0]    be,
    input  logic [WORD_W-1:0]   wdata,
    output logic [ADDR_W-1:0]   maddr,
    output logic [1:0]          base,
    output logic [LANES-1:0]    cs_sel,
    output logic [LANES-1:0]    we_sel,
    output logic [WORD_W-1:0]   lane_data
);

    always_comb begin
        unique case (mode)
            MODE_W32: begin
                maddr  = haddr[ADDR_W+1:2];
                base   = 2'd0;
                cs_sel = 4'b1111;
            end
            MODE_W16: begin
                maddr  = haddr[ADDR_W:1];
                base   = {haddr[ADDR_W+1], 1'b0};
                cs_sel = haddr[ADDR_W+1] ? 4'b1100 : 4'b0011;
            end
            default: begin
                maddr  = haddr[ADDR_W-1:0];
                base   = haddr[ADDR_W+1:ADDR_W];
                cs_sel = 4'b0001 << haddr[ADDR_W+1:ADDR_W];
            end
        endcase
    end

    // Each physical lane takes the host byte at its offset from the base lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [1:0] rel;
        assign rel = 2'(g) - base;
        assign lane_data[g*BYTE_W +: BYTE_W] = wdata[{rel, 3'b000} +: BYTE_W];
        assign we_sel[g] = cs_sel[g] & be[rel];
    end

endmodule

// File: rtl/sram_read_merge.sv
module sram_read_merge
    import sram_ctrl_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [1:0]        base,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] rdata
);

    for (genvar k = 0; k < LANES; k++) begin : g_byte
        logic [1:0] src;
        logic       keep;
        assign src  = 2'(k) + base;
        assign keep = (mode == MODE_W32) || ((mode == MODE_W16) && (k < 2)) || (k == 0);
        assign rdata[k*BYTE_W +: BYTE_W] = keep ? din[{src, 3'b000} +: BYTE_W] : '0;
    end

endmodule

// File: rtl/sram_bank_ctrl.sv
module sram_bank_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W         = 19,
    parameter int unsigned CLK_PS         = 10000,
    parameter int unsigned ADDR_SETUP_PS  = 2000,
    parameter int unsigned WR_PULSE_PS    = 12000,
    parameter int unsigned RD_STROBE_PS   = 18000,
    parameter int unsigned WR_HOLD_PS     = 1000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W+1:0]     req_addr,
    input  logic [31:0]           req_wdata,
    input  logic [3:0]            req_be,
    input  logic [1:0]            cfg_mode,
    output logic                  req_ack,
    output logic [31:0]           rsp_rdata,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [3:0]            mem_cs_n,
    output logic [3:0]            mem_we_n,
    output logic                  mem_oe_n,
    output logic [31:0]           mem_dout,
    input  logic [31:0]           mem_din,
    output logic                  mem_dq_oe
);

    localparam int unsigned SETUP_C = ps_to_cycles(ADDR_SETUP_PS, CLK_PS);
    localparam int unsigned WR_C    = ps_to_cycles(WR_PULSE_PS, CLK_PS);
    localparam int unsigned RD_C    = ps_to_cycles(RD_STROBE_PS, CLK_PS);
    localparam int unsigned HOLD_C  = ps_to_cycles(WR_HOLD_PS, CLK_PS);
    localparam int unsigned MAX_AB  = (SETUP_C > WR_C) ? SETUP_C : WR_C;
    localparam int unsigned MAX_CD  = (RD_C > HOLD_C) ? RD_C : HOLD_C;
    localparam int unsigned MAX_C   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int unsigned CNT_W   = $clog2(MAX_C + 1);

    typedef struct packed {
        phase_e                phase;
        logic [CNT_W-1:0]      cnt;
        logic                  wr;
        logic [1:0]            mode;
        logic [1:0]            base;
        logic [LANES-1:0]      we_sel;
        logic [ADDR_W-1:0]     addr;
        logic [WORD_W-1:0]     wdata;
        logic [LANES-1:0]      cs_n;
        logic [LANES-1:0]      we_n;
        logic                  oe_n;
        logic                  dq_oe;
        logic                  ack;
        logic [WORD_W-1:0]     rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] map_addr;
    logic [1:0]        map_base;
    logic [LANES-1:0]  map_cs;
    logic [LANES-1:0]  map_we;
    logic [WORD_W-1:0] map_data;
    logic [WORD_W-1:0] rd_word;

    sram_lane_map #(.ADDR_W(ADDR_W)) i_map (
        .mode      (cfg_mode),
        .haddr     (req_addr),
        .be        (req_be),
        .wdata     (req_wdata),
        .maddr     (map_addr),
        .base      (map_base),
        .cs_sel    (map_cs),
        .we_sel    (map_we),
        .lane_data (map_data)
    );

    sram_read_merge i_merge (
        .mode  (ctl_q.mode),
        .base  (ctl_q.base),
        .din   (mem_din),
        .rdata (rd_word)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ack = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                // The acknowledge cycle doubles as the mandatory idle cycle.
                if (req_valid && !ctl_q.ack) begin
                    ctl_d.phase  = PH_SETUP;
                    ctl_d.cnt    = CNT_W'(SETUP_C - 1);
                    ctl_d.wr     = req_write;
                    ctl_d.mode   = cfg_mode;
                    ctl_d.base   = map_base;
                    ctl_d.we_sel = map_we & {LANES{req_write}};
                    ctl_d.addr   = map_addr;
                    ctl_d.wdata  = map_data;
                    ctl_d.cs_n   = ~map_cs;
                    ctl_d.dq_oe  = req_write;
                end
            end
            PH_SETUP: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.phase = PH_STROBE;
                    if (ctl_q.wr) begin
                        ctl_d.cnt  = CNT_W'(WR_C - 1);
                        ctl_d.we_n = ~ctl_q.we_sel;
                    end else begin
                        ctl_d.cnt  = CNT_W'(RD_C - 1);
                        ctl_d.oe_n = 1'b0;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (ctl_q.cnt == '0) begin
                    if (ctl_q.wr) begin
                        ctl_d.phase = PH_HOLD;
                        ctl_d.cnt   = CNT_W'(HOLD_C - 1);
                        ctl_d.we_n  = '1;
                    end else begin
                        ctl_d.phase = PH_IDLE;
                        ctl_d.cs_n  = '1;
                        ctl_d.oe_n  = 1'b1;
                        ctl_d.ack   = 1'b1;
                        ctl_d.rdata = rd_word;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.cs_n  = '1;
                    ctl_d.dq_oe = 1'b0;
                    ctl_d.ack   = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.phase <= PH_IDLE;
            ctl_q.cs_n  <= '1;
            ctl_q.we_n  <= '1;
            ctl_q.oe_n  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ack   = ctl_q.ack;
    assign rsp_rdata = ctl_q.rdata;
    assign mem_addr  = ctl_q.addr;
    assign mem_cs_n  = ctl_q.cs_n;
    assign mem_we_n  = ctl_q.we_n;
    assign mem_oe_n  = ctl_q.oe_n;
    assign mem_dout  = ctl_q.wdata;
    assign mem_dq_oe = ctl_q.dq_oe;

endmodule

// File: rtl/sram_bank_ctrl_chk.sv
module sram_bank_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] mem_cs_n,
    input logic [3:0] mem_we_n,
    input logic       mem_oe_n,
    input logic       mem_dq_oe,
    input logic       req_ack
);

    p_dq_oe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_dq_off_with_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_dq_oe) |-> (&mem_cs_n));

    p_we_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(~mem_we_n & mem_cs_n)));

    p_we_rise_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&mem_we_n) |-> !(&mem_cs_n));

    p_oe_only_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (&mem_we_n));

    p_cs_pattern_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_cs_n) != 3);

    p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    p_ack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (&mem_cs_n));

    p_gap_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> (&mem_cs_n));

endmodule

bind sram_bank_ctrl sram_bank_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe),
    .req_ack   (req_ack)
);

// File: tb/test_sram_bank_ctrl.sv
`timescale 1ns/1ps
module test_sram_bank_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int unsigned CLK_PS = 10000;

    function automatic int unsigned cyc(input int unsigned ps);
        int unsigned n;
        n = ps / CLK_PS;
        if (n * CLK_PS < ps) n++;
        if (n == 0) n = 1;
        return n;
    endfunction

    localparam int unsigned SU_C = cyc(2000);
    localparam int unsigned WP_C = cyc(12000);
    localparam int unsigned RS_C = cyc(18000);
    localparam int unsigned HD_C = cyc(1000);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic [1:0]  cfg_mode = '0;
    logic        req_ack;
    logic [31:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic [3:0]  mem_we_n;
    logic        mem_oe_n;
    logic [31:0] mem_dout;
    logic [31:0] mem_din = '0;
    logic        mem_dq_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_bank_ctrl i_sram_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .cfg_mode(cfg_mode),
        .req_ack(req_ack), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dout(mem_dout), .mem_din(mem_din),
        .mem_dq_oe(mem_dq_oe)
    );

    int vectors = 0;
    int fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory behind the pins, and the expected contents per requirements.
    logic [7:0] pin_mem [int unsigned];
    logic [7:0] exp_mem [int unsigned];

    function automatic int unsigned mkey(input int unsigned lane, input int unsigned a);
        return (lane << 19) | a;
    endfunction

    function automatic logic [7:0] pin_rd(input int unsigned k);
        return pin_mem.exists(k) ? pin_mem[k] : 8'h00;
    endfunction

    function automatic logic [7:0] exp_rd(input int unsigned k);
        return exp_mem.exists(k) ? exp_mem[k] : 8'h00;
    endfunction

    typedef struct packed {
        logic        rd;
        logic [31:0] data;
    } sb_item_t;
    sb_item_t sb_q[$];

    logic [3:0] exp_cs = '0;
    logic [3:0] exp_we = '0;
    string      exp_tag = "R2";

    // Driver: computes the expected mapping, pushes to the scoreboard, runs the handshake.
    task automatic access(input logic [1:0] mode, input logic wr, input logic [20:0] addr,
                          input logic [31:0] wdata, input logic [3:0] be, input string tag);
        int unsigned pa;
        int unsigned base;
        int unsigned width;
        logic [3:0]  csm;
        logic [3:0]  wem;
        logic [31:0] rexp;
        sb_item_t    it;
        case (mode)
            2'b00: begin pa = addr[20:2]; base = 0; width = 4; csm = 4'b1111; end
            2'b01: begin pa = addr[19:1]; base = addr[20] ? 2 : 0; width = 2;
                         csm = addr[20] ? 4'b1100 : 4'b0011; end
            default: begin pa = addr[18:0]; base = addr[20:19]; width = 1;
                           csm = 4'b0001 << addr[20:19]; end
        endcase
        wem = '0;
        rexp = '0;
        for (int k = 0; k < width; k++) begin
            int unsigned ln;
            ln = (base + k) % 4;
            if (wr && be[k]) begin
                wem[ln] = 1'b1;
                exp_mem[mkey(ln, pa)] = wdata[8*k +: 8];
            end
            rexp[8*k +: 8] = exp_rd(mkey(ln, pa));
        end
        exp_cs  = csm;
        exp_we  = wem;
        exp_tag = tag;
        it.rd   = !wr;
        it.data = rexp;
        sb_q.push_back(it);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = wdata;
        req_be    = be;
        cfg_mode  = mode;
        do @(negedge clk); while (!req_ack);
        req_valid = 1'b0;
        if (wr) begin
            for (int k = 0; k < width; k++) begin
                int unsigned ln;
                ln = (base + k) % 4;
                check(pin_rd(mkey(ln, pa)) == exp_rd(mkey(ln, pa)), tag,
                      "byte stored at mapped bank/address",
                      {24'h0, pin_rd(mkey(ln, pa))}, {24'h0, exp_rd(mkey(ln, pa))});
            end
        end
    endtask

    // Pin model and monitor, all sampled on the falling edge.
    logic [3:0] prev_we = 4'hF;
    logic       active = 1'b0;
    logic       ack_prev = 1'b0;
    int unsigned pre_n = 0, wr_n = 0, rd_n = 0, post_n = 0, dq_n = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 4; i++) begin
                if (!prev_we[i] && mem_we_n[i])
                    pin_mem[mkey(i, mem_addr)] = mem_dout[8*i +: 8];
                mem_din[8*i +: 8] = (!mem_cs_n[i] && mem_we_n[i] && !mem_oe_n)
                                    ? pin_rd(mkey(i, mem_addr)) : 8'hEE;
            end
            prev_we = mem_we_n;

            if (!(&mem_cs_n)) begin
                active = 1'b1;
                check((~mem_cs_n) == exp_cs, exp_tag, "chip select pattern",
                      {28'h0, ~mem_cs_n}, {28'h0, exp_cs});
                if (!(&mem_we_n)) begin
                    wr_n++;
                    check((~mem_we_n) == exp_we, "R3", "write enable lanes",
                          {28'h0, ~mem_we_n}, {28'h0, exp_we});
                end else if (!mem_oe_n) begin
                    rd_n++;
                end else if (wr_n == 0 && rd_n == 0) begin
                    pre_n++;
                end else begin
                    post_n++;
                end
                if (mem_dq_oe) dq_n++;
            end else if (active) begin
                active = 1'b0;
                check(req_ack == 1'b1, "R9", "ack in first idle cycle", {31'h0, req_ack}, 32'h1);
                if (rd_n > 0) begin
                    check(pre_n == SU_C, "R7", "read setup cycles", pre_n, SU_C);
                    check(rd_n == RS_C, "R7", "output enable low cycles", rd_n, RS_C);
                    check(post_n == 0 && wr_n == 0, "R7", "no write strobe in read", post_n + wr_n, 0);
                    check(dq_n == 0, "R8", "no drive during read", dq_n, 0);
                end else if (wr_n > 0) begin
                    check(pre_n == SU_C, "R6", "write address setup cycles", pre_n, SU_C);
                    check(wr_n == WP_C, "R6", "write pulse cycles", wr_n, WP_C);
                    check(post_n == HD_C, "R6", "hold cycles after write enable rise", post_n, HD_C);
                    check(dq_n == SU_C + WP_C + HD_C, "R8", "drive enable span", dq_n, SU_C + WP_C + HD_C);
                end else begin
                    check(pre_n == SU_C + WP_C + HD_C, "R3", "masked-off write length",
                          pre_n, SU_C + WP_C + HD_C);
                    check(dq_n == pre_n, "R8", "drive enable span masked write", dq_n, pre_n);
                end
                pre_n = 0; wr_n = 0; rd_n = 0; post_n = 0; dq_n = 0;
            end

            if (ack_prev) begin
                check(!req_ack, "R9", "ack lasts one cycle", {31'h0, req_ack}, 32'h0);
                check(&mem_cs_n, "R9", "idle cycle after ack", {28'h0, mem_cs_n}, 32'hF);
            end
            if (req_ack) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9", "ack with nothing outstanding", 32'h1, 32'h0);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    if (it.rd)
                        check(rsp_rdata == it.data, exp_tag, "read data", rsp_rdata, it.data);
                end
            end
            ack_prev = req_ack;
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: got no completion expected run end");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        check(mem_cs_n == 4'hF && mem_we_n == 4'hF && mem_oe_n && !mem_dq_oe && !req_ack,
              "R1", "outputs in reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ack},
              {4'hF, 4'hF, 3'b100});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(mem_cs_n == 4'hF && mem_we_n == 4'hF && mem_oe_n && !mem_dq_oe && !req_ack,
              "R1", "outputs after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ack},
              {4'hF, 4'hF, 3'b100});

        // R2 word mode, R3 masks
        access(2'b00, 1'b1, 21'h000010, 32'h11223344, 4'hF, "R2");
        access(2'b00, 1'b0, 21'h000010, 32'h0, 4'h0, "R2");
        access(2'b00, 1'b1, 21'h000010, 32'hAABBCCDD, 4'b0101, "R3");
        access(2'b00, 1'b0, 21'h000010, 32'h0, 4'h0, "R3");
        access(2'b00, 1'b1, 21'h000010, 32'hFFFFFFFF, 4'b0000, "R3");
        access(2'b00, 1'b0, 21'h000010, 32'h0, 4'h0, "R3");

        // R4 halfword banks, then a word read across both pairs
        access(2'b01, 1'b1, 21'h100246, 32'h0000BEEF, 4'b0011, "R4");
        access(2'b01, 1'b1, 21'h000246, 32'h00001234, 4'b0010, "R4");
        access(2'b01, 1'b0, 21'h100246, 32'h0, 4'h0, "R4");
        access(2'b01, 1'b0, 21'h000246, 32'h0, 4'h0, "R4");
        access(2'b00, 1'b0, 21'h00048C, 32'h0, 4'h0, "R4");

        // R5 byte banks
        for (int b = 0; b < 4; b++)
            access(2'b10, 1'b1, 21'((b << 19) | 7), 32'(8'hA0 + b), 4'b0001, "R5");
        for (int b = 0; b < 4; b++)
            access(2'b10, 1'b0, 21'((b << 19) | 7), 32'h0, 4'h0, "R5");
        access(2'b11, 1'b0, 21'((2 << 19) | 7), 32'h0, 4'h0, "R5");
        access(2'b10, 1'b1, 21'((1 << 19) | 7), 32'h55, 4'b1110, "R3");
        access(2'b10, 1'b0, 21'((1 << 19) | 7), 32'h0, 4'h0, "R5");
        access(2'b00, 1'b0, 21'h00001C, 32'h0, 4'h0, "R5");

        // Word pattern sweep (R2, R7)
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 8; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            access(2'b00, 1'b1, 21'(32'h1000 + i * 4 + (i << 17)), lfsr, 4'hF, "R2");
        end
        for (int i = 7; i >= 0; i--)
            access(2'b00, 1'b0, 21'(32'h1000 + i * 4 + (i << 17)), 32'h0, 4'h0, "R7");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R9", "all requests acknowledged", sb_q.size(), 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule